// File: doc/BRIEF.md
# Low-Power Stop Mode Sequencer

This block is the mode-control state machine of a supply supervisor. It controls how the supervisor parks the microcontroller in a low-power stop state and how it brings it back. A stop request from the serial command decoder does not take effect when it is decoded. It only takes effect when the chip-select line rises to close the frame that carried it. Entry is possible only from the running mode, which covers both Normal and Standby operation.

In stop mode the watchdog is disabled. The only wake source is an overcurrent flag from the microcontroller supply regulator. That flag is deglitched: it must stay high for a programmable number of clock cycles before it counts as a wake. After a wake the block re-enables the watchdog and waits for the microcontroller to clear it. A clear inside the allowed time returns the block to running mode. If no clear arrives in time, the block issues a one-cycle reset request and settles in a normal-request mode. It stays there until the restarted microcontroller clears the watchdog.

Top module: `stop_seq`

## Requirements
- R1: After reset, mode_o is 0 (run), wd_en_o is 1 and rst_req_o is 0. The mode codes are run=0, stop=1, wake-wait=2 and normal-request=3.
- R2: A stop command (stop_cmd_i high while cs_n_i is low) does not change mode_o by itself. mode_o becomes 1 in the cycle after the clock edge at which cs_n_i is first sampled high again.
- R3: Arming is cancelled at the start of every frame (cs_n_i falling). A stop command seen while cs_n_i is high, followed by a frame with no stop command, leaves mode_o at 0.
- R4: A stop frame has no effect while mode_o is 2 or 3.
- R5: wd_en_o is 0 exactly while mode_o is 1.
- R6: In stop mode, oc_i high on DGL_CYC consecutive clock edges moves mode_o to 2 after the last of those edges. oc_i has no effect in run mode.
- R7: In stop mode, oc_i falling before DGL_CYC consecutive high edges restarts the count, and mode_o stays 1.
- R8: A wd_clr_i pulse in mode 2 moves mode_o to 0 on the next edge, and rst_req_o stays 0.
- R9: If mode 2 lasts WD_CYC clock edges without wd_clr_i, mode_o becomes 3 and rst_req_o is high for exactly one cycle.
- R10: A wd_clr_i pulse in mode 3 moves mode_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Serial chip select, active low, synchronous to clk_i |
| stop_cmd_i | input | 1 | Decoded stop command flag |
| oc_i | input | 1 | Regulator overcurrent detect |
| wd_clr_i | input | 1 | Watchdog cleared strobe |
| mode_o | output | 2 | Current mode code |
| wd_en_o | output | 1 | Watchdog enable |
| rst_req_o | output | 1 | Microcontroller reset request pulse |

## Verification
Any fault in the arming flag shows up at the end of the first frame. Stop entry comes one cycle too early, one cycle too late, or after a frame that carried no command, and mode_o and wd_en_o are wrong on the next cycle. A deglitch counter that fails to clear, or that stops one count early or late, moves the wake edge by at least one cycle. Wake-timer faults move the reset pulse or stretch it. A reference model is compared on every clock, so each of these faults is caught within one cycle of the first divergence.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_STOP = 2'd1,
    MODE_WAKE = 2'd2,
    MODE_NREQ = 2'd3
  } mode_e;
endpackage

// File: rtl/stop_dwell_cnt.sv
module stop_dwell_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign done_o = en_i && (cnt_q == LAST);

  // count consecutive enabled edges; any gap restarts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (en_i && !done_o)  cnt_q <= cnt_q + 1'b1;
    else                       cnt_q <= '0;
  end

  a_r7_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r7_gap_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/stop_arm.sv
module stop_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic cs_n_i,
  input  logic stop_cmd_i,
  output logic go_stop_o
);
  logic cs_q, armed_q;
  logic cs_rise, cs_fall;

  assign cs_rise   = !cs_q && cs_n_i;
  assign cs_fall   = cs_q && !cs_n_i;
  assign go_stop_o = run_i && cs_rise && (armed_q || stop_cmd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q    <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      cs_q    <= cs_n_i;
      armed_q <= run_i && !cs_rise && !cs_fall && (armed_q || stop_cmd_i);
    end
  end

  a_r3_frame_start_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> !armed_q);
  a_r2_go_only_on_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_stop_o |-> $past(!cs_n_i) && cs_n_i);
endmodule

// File: rtl/stop_seq.sv
module stop_seq
  import stop_seq_pkg::*;
#(
  parameter int unsigned DGL_CYC = 40,
  parameter int unsigned WD_CYC  = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_n_i,
  input  logic       stop_cmd_i,
  input  logic       oc_i,
  input  logic       wd_clr_i,
  output logic [1:0] mode_o,
  output logic       wd_en_o,
  output logic       rst_req_o
);
  mode_e mode_q, mode_d;
  logic  go_stop, wake, timeout, rst_q;

  stop_arm i_arm (
    .clk_i, .rst_ni,
    .run_i     (mode_q == MODE_RUN),
    .cs_n_i,
    .stop_cmd_i,
    .go_stop_o (go_stop)
  );

  stop_dwell_cnt #(.LIMIT(DGL_CYC)) i_dgl (
    .clk_i, .rst_ni,
    .en_i   (mode_q == MODE_STOP && oc_i),
    .done_o (wake)
  );

  stop_dwell_cnt #(.LIMIT(WD_CYC)) i_wdt (
    .clk_i, .rst_ni,
    .en_i   (mode_q == MODE_WAKE && !wd_clr_i),
    .done_o (timeout)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN:  if (go_stop) mode_d = MODE_STOP;
      MODE_STOP: if (wake)    mode_d = MODE_WAKE;
      MODE_WAKE: if (wd_clr_i) mode_d = MODE_RUN;
                 else if (timeout) mode_d = MODE_NREQ;
      MODE_NREQ: if (wd_clr_i) mode_d = MODE_RUN;
      default:   mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RUN;
      rst_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rst_q  <= timeout;
    end
  end

  assign mode_o    = mode_q;
  assign wd_en_o   = (mode_q != MODE_STOP);
  assign rst_req_o = rst_q;

  a_r4_no_stop_from_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WAKE || mode_q == MODE_NREQ) |=> mode_q != MODE_STOP);
  a_r6_stop_holds_without_oc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP && !oc_i) |=> mode_q == MODE_STOP);
  a_r8_clear_returns_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WAKE && wd_clr_i) |=> mode_q == MODE_RUN && !rst_req_o);
  a_r9_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r9_rst_in_nreq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> mode_q == MODE_NREQ);
endmodule

// File: tb/test_stop_seq.sv
module test_stop_seq;
  localparam int CLK_PER = 10;
  localparam int DGL = 6;
  localparam int WDC = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, cmd = 1'b0, oc = 1'b0, clr = 1'b0;
  logic [1:0] mode;
  logic wd_en, rst_req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  stop_seq #(.DGL_CYC(DGL), .WD_CYC(WDC)) i_stop_seq (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .stop_cmd_i(cmd),
    .oc_i(oc), .wd_clr_i(clr), .mode_o(mode), .wd_en_o(wd_en), .rst_req_o(rst_req));

  // behavioural reference model
  int m_mode = 0, m_dg = 0, m_wt = 0;
  bit m_arm = 0, m_csp = 1, m_rst = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_dg = 0; m_wt = 0; m_arm = 0; m_csp = 1; m_rst = 0;
    end else begin
      automatic bit rise = !m_csp && cs_n;
      automatic bit fall = m_csp && !cs_n;
      automatic int nm = m_mode;
      automatic bit wk = (m_mode == 1) && oc && (m_dg == DGL-1);
      automatic bit to = (m_mode == 2) && !clr && (m_wt == WDC-1);
      if (m_mode == 0 && rise && (m_arm || cmd)) nm = 1;
      else if (wk) nm = 2;
      else if (m_mode >= 2 && clr) nm = 0;
      else if (to) nm = 3;
      m_arm = (m_mode == 0) && !rise && !fall && (m_arm || cmd);
      m_dg  = (m_mode == 1 && oc && !wk) ? m_dg + 1 : 0;
      m_wt  = (m_mode == 2 && !clr && !to) ? m_wt + 1 : 0;
      m_rst = to;
      m_csp = cs_n;
      m_mode = nm;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("model mode", mode, m_mode);
    chk("model wd_en", wd_en, m_mode != 1);
    chk("model rst_req", rst_req, m_rst);
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic frame(bit with_cmd);
    step; cs_n = 1'b0;
    step; cmd = with_cmd;
    step; cmd = 1'b0;
    chk("R2 no entry on decode", mode, (with_cmd && mode == 0) ? 0 : mode);
    step; cs_n = 1'b1;
    step;
  endtask

  task automatic wake_up();
    oc = 1'b1;
    step(DGL-1);
    chk("R6 before deglitch end", mode, 1);
    step;
    chk("R6 wake after deglitch", mode, 2);
    chk("R5 wd_en after wake", wd_en, 1);
    oc = 1'b0;
  endtask

  initial begin
    step(2);
    chk("R1 mode", mode, 0);
    chk("R1 wd_en", wd_en, 1);
    chk("R1 rst_req", rst_req, 0);
    rst_n = 1'b1;
    oc = 1'b1; step(DGL*3); oc = 1'b0;
    chk("R6 oc ignored in run", mode, 0);
    frame(1'b0);
    chk("R3 empty frame", mode, 0);
    step; cmd = 1'b1; step; cmd = 1'b0; step;
    frame(1'b0);
    chk("R3 disarm at frame start", mode, 0);
    frame(1'b1);
    chk("R2 stop after cs rise", mode, 1);
    chk("R5 wd_en low in stop", wd_en, 0);
    oc = 1'b1; step(DGL-1); oc = 1'b0; step;
    oc = 1'b1; step(DGL-2); oc = 1'b0; step;
    chk("R7 glitches rejected", mode, 1);
    wake_up();
    step(3); clr = 1'b1; step; clr = 1'b0;
    chk("R8 clear returns run", mode, 0);
    chk("R8 no reset", rst_req, 0);
    frame(1'b1);
    chk("R2 second stop", mode, 1);
    wake_up();
    step(WDC-1);
    chk("R9 still waiting", mode, 2);
    step;
    chk("R9 normal request", mode, 3);
    chk("R9 reset pulse", rst_req, 1);
    step;
    chk("R9 pulse one cycle", rst_req, 0);
    frame(1'b1);
    chk("R4 stop ignored in nreq", mode, 3);
    clr = 1'b1; step; clr = 1'b0;
    chk("R10 clear from nreq", mode, 0);
    step(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule